// File: doc/BRIEF.md
# Any-Pin Function Routing Crossbar

This block lets each alternate peripheral function be placed on any one of a range of general-purpose pads. Every function has a 7-bit selector. A selector of 0 leaves the function unplaced. A selector k places the function on pad k+7.

Software programs the selectors through 32-bit words, with two functions in each word. Each function occupies its own byte lane, and each lane has its own per-bit write-enable field in the upper half of the word. A partial write therefore never disturbs the neighbouring function.

For every pad the block produces the output value and output-enable of the function placed there, plus a flag that says a function owns the pad. In the other direction, each function receives the input level of its pad. When two functions name the same pad, the lower-numbered function keeps it. Choosing between pad types and the electrical pad itself belong to neighbouring logic.

Top module: `pad_fn_xbar`

## Requirements
- R1: After reset every selector is 0. No pad is routed, every pad_out and pad_oe bit is 0, every fn_in bit is 1, and the read data of every word is 0.
- R2: Function f lives in the word at byte address (f/2)*4. Address bits 1:0 are ignored. An even f uses control bits 6:0 with write-enable bits 22:16. An odd f uses control bits 14:8 with write-enable bits 30:24. A write to a word past the last function changes nothing, and reading such a word returns 0.
- R3: A write changes a selector bit only when the matching write-enable bit is 1 in that same write. A write with no enable bit set leaves the word unchanged.
- R4: Read data shows each selector in its control bits. All other bits, including the write-enable positions, read as 0.
- R5: A selector k with 1 <= k <= 64 routes its function to pad k+7. On that pad, pad_out equals the function's fn_out, pad_oe equals the function's fn_oe, and pad_routed is 1.
- R6: A selector of 0, or of 65 or more (which would name a pad past the last one, 71), leaves the function unplaced. Pads 0 to 7 are never routed.
- R7: When several functions select the same pad, only the lowest-numbered of them drives that pad. If that function is later unmapped, the next-lowest one takes the pad over.
- R8: A function that owns a pad sees that pad's pad_in level on fn_in. An unplaced function, or one that lost a conflict, sees 1.
- R9: A pad that no function owns has pad_out=0, pad_oe=0 and pad_routed=0.
- R10: The routing outputs and the read data reflect a write from the clock edge that accepts it onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the selector words |
| reg_addr | input | ADDR_W (5) | Byte address for both write and read |
| reg_wdata | input | 32 | Write data: control bits in the low half, write-enable bits in the high half |
| reg_rdata | output | 32 | Selector readback of the addressed word |
| fn_out | input | NUM_FN (8) | Output value from each function |
| fn_oe | input | NUM_FN (8) | Output-enable from each function |
| fn_in | output | NUM_FN (8) | Input level returned to each function |
| pad_in | input | NUM_PADS (72) | Input level of each pad |
| pad_out | output | NUM_PADS (72) | Output value to drive on each pad |
| pad_oe | output | NUM_PADS (72) | Output-enable for each pad |
| pad_routed | output | NUM_PADS (72) | Pad is owned by a function |

## Verification
A corrupted selector shows up right after the edge that stored it. The read data of its word is wrong, and a routed flag appears on the wrong pad or goes missing. A wrongly decoded mask or lane shows as a change in the neighbouring function's byte. A faulty conflict rule shows as the wrong fn_out value on a shared pad, and as a pad level leaking into the losing function's fn_in instead of the idle 1. All of these are visible in the sampling interval that directly follows the write.

// File: rtl/pad_fn_xbar.sv
module pad_fn_xbar #(
  parameter int NUM_FN   = 8,
  parameter int SEL_W    = 7,
  parameter int NUM_PADS = 72,
  parameter int PAD_OFS  = 7,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_FN-1:0]   fn_out,
  input  logic [NUM_FN-1:0]   fn_oe,
  output logic [NUM_FN-1:0]   fn_in,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_routed
);
  localparam int LANE = 8;
  localparam int MASK_SH = 16;

  logic [SEL_W-1:0] sel_q [NUM_FN];
  logic [NUM_FN-1:0] valid, granted;
  int unsigned word_idx;
  int unsigned tgt [NUM_FN];

  assign word_idx = 32'(reg_addr[ADDR_W-1:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FN; f++) sel_q[f] <= '0;
    end else if (reg_we) begin
      for (int f = 0; f < NUM_FN; f++)
        if (word_idx == f / 2)
          for (int b = 0; b < SEL_W; b++)
            if (reg_wdata[MASK_SH + LANE*(f%2) + b])
              sel_q[f][b] <= reg_wdata[LANE*(f%2) + b];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int f = 0; f < NUM_FN; f++)
      if (word_idx == f / 2) reg_rdata[LANE*(f%2) +: SEL_W] = sel_q[f];
  end

  always_comb begin
    for (int f = 0; f < NUM_FN; f++) begin
      tgt[f]   = 32'(sel_q[f]) + PAD_OFS;
      valid[f] = (sel_q[f] != '0) && (tgt[f] < NUM_PADS);
    end
    for (int f = 0; f < NUM_FN; f++) begin
      granted[f] = valid[f];
      for (int g = 0; g < f; g++)
        if (valid[g] && sel_q[g] == sel_q[f]) granted[f] = 1'b0;
    end
  end

  always_comb begin
    pad_out = '0;
    pad_oe = '0;
    pad_routed = '0;
    for (int p = 0; p < NUM_PADS; p++)
      for (int f = 0; f < NUM_FN; f++)
        if (granted[f] && tgt[f] == p) begin
          pad_out[p]    = fn_out[f];
          pad_oe[p]     = fn_oe[f];
          pad_routed[p] = 1'b1;
        end
  end

  always_comb begin
    fn_in = '1;
    for (int f = 0; f < NUM_FN; f++)
      if (granted[f]) fn_in[f] = pad_in[tgt[f]];
  end

  a_r4_rdata_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 32'hFFFF_8080) == 32'h0);

  a_r9_oe_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~pad_routed) == '0);

  a_r6_low_pads_free: assert property (@(posedge clk) disable iff (!rst_n)
    pad_routed[PAD_OFS:0] == '0);

  a_r7_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pad_routed) <= NUM_FN);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (pad_routed == '0 && fn_in == '1));

  for (genvar f = 0; f < NUM_FN; f++) begin : g_chk
    a_r3_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we || word_idx != f / 2 ||
       reg_wdata[MASK_SH + LANE*(f%2) +: SEL_W] == '0) |=> $stable(sel_q[f]));
    a_r8_unmapped_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[f] == '0 |-> fn_in[f]);
  end
endmodule

// File: tb/pad_fn_xbar_tb_top.sv
module pad_fn_xbar_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  fn_out = '0, fn_oe = '0, fn_in;
  logic [71:0] pad_in = '1, pad_out, pad_oe, pad_routed;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pad_fn_xbar dut_i (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .fn_out, .fn_oe, .fn_in, .pad_in, .pad_out, .pad_oe, .pad_routed);

  // address, write data, expected readback (cumulative from reset)
  localparam logic [31:0] VEC [7][3] = '{
    '{32'd0,  32'h007F_0005, 32'h0000_0005},  // R2 even lane
    '{32'd0,  32'h7F00_0900, 32'h0000_0905},  // R2 odd lane
    '{32'd0,  32'h0003_007A, 32'h0000_0906},  // R3 two enable bits only
    '{32'd4,  32'hFFFF_4121, 32'h0000_4121},  // R4 enable bits read as 0
    '{32'd6,  32'h0000_7F7F, 32'h0000_4121},  // R3 no enable, R2 low bits ignored
    '{32'd16, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 word past the end
    '{32'd8,  32'h7F7F_0A0A, 32'h0000_0A0A}   // R7 conflict setup
  };

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  function automatic logic [71:0] bits(int a, int b, int c, int d);
    logic [71:0] v = '0;
    if (a >= 0) v[a] = 1;
    if (b >= 0) v[b] = 1;
    if (c >= 0) v[c] = 1;
    if (d >= 0) v[d] = 1;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 routed", pad_routed, '0);
    chk("R1 fn_in", fn_in, 8'hFF);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 pad_oe", pad_oe, '0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][0][4:0], VEC[i][1]);
      reg_addr = VEC[i][0][4:0];
      #1 chk("R2/R3/R4 readback", reg_rdata, VEC[i][2]);
    end
    reg_addr = 5'd4;
    #1 chk("R2 word1 untouched by out-of-range write", reg_rdata, 32'h4121);

    // sel0=6->13, sel1=9->16, sel2=33->40, sel3=65 unmapped, sel4=10->17, sel5=10 loses
    fn_out = 8'hFF; fn_oe = 8'h0F;
    pad_in = ~bits(13, 40, 17, -1);
    #2;
    chk("R5 R6 routed set", pad_routed, bits(13, 16, 40, 17));
    chk("R5 pad_out", pad_out, bits(13, 16, 40, 17));
    chk("R5 pad_oe", pad_oe, bits(13, 16, 40, -1));
    chk("R8 fn_in", fn_in, 8'hEA);
    fn_out = 8'b1110_1111;
    #2 chk("R7 lowest function drives pad 17", pad_out[17], 1'b0);
    fn_out = 8'b0010_0000;
    #2 chk("R9 unrouted pads drive 0", pad_out & ~pad_routed, '0);

    wr(5'd8, 32'h007F_0000);
    chk("R10 R7 next function takes pad 17", pad_out[17], 1'b1);
    chk("R8 new owner sees pad 17", fn_in[5], 1'b0);
    chk("R8 unmapped f4 idle", fn_in[4], 1'b1);

    wr(5'd12, 32'h7F7F_0140);
    chk("R5 sel 64 -> pad 71 and sel 1 -> pad 8", pad_routed & bits(71, 8, -1, -1), bits(71, 8, -1, -1));
    pad_in[71] = 0;
    #2 chk("R8 pad 71 input", fn_in[6], 1'b0);
    chk("R6 pads 0-7 free", pad_routed[7:0], 8'h00);

    rst_n = 0;
    @(negedge clk); rst_n = 1;
    reg_addr = 5'd12;
    #1 chk("R1 reset clears selectors", reg_rdata, 0);
    chk("R1 reset clears routing", pad_routed, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule